// File: doc/BRIEF.md
# SDRAM Bank Decode and Address Multiplexer

This block turns a physical byte address into an SDRAM access target. Eight chip selects each own a window of the physical space, given as a programmable first and last 1 MB granule and gated by an enable bit. The enabled bank whose window holds the address is selected. The block then cuts the address into column, logical-bank and row fields, using the geometry programmed for that bank, and presents them on a 14-bit shared memory address bus.

A memory controller calls on the block once per access. In the activate cycle it sets the phase select to row and takes the row field. In the read or write cycle it sets the phase select to column and takes the column field, with bit 10 carrying the auto-precharge choice. The logical bank number is always present on its own outputs. Error flags report an address that no bank covers, windows that overlap, and a geometry that would leave holes in the address space for the current data bus width. All outputs are registered and appear one clock after the inputs are sampled.

Top module: `sdr_bank_mux`

## Requirements
- R1: One clock after the inputs are sampled, `cs_o[i]` is high for the enabled bank i where start_i ≤ addr[31:20] ≤ end_i. Start and end are 12-bit granule numbers, and bank i's pair sits at bits [12i+11:12i] of its bus.
- R2: A bank whose `bank_en_i` bit is 0 never asserts its chip select, even when its window overlaps an enabled bank or holds the address.
- R3: Any address at or above 1 GB (addr[31:30] ≠ 0) selects no bank and raises `miss_o`, whatever the programmed windows are.
- R4: When more than one enabled bank matches, only the lowest-numbered one is asserted and `overlap_o` is 1. At most one chip select is ever high.
- R5: When no enabled bank matches, `cs_o`, `ma_o`, `ba_o` and `cfg_err_o` are 0 and `miss_o` is 1.
- R6: In the row phase (`col_phase_i`=0), `ma_o` carries the row field zero-extended. The row field is R bits wide (R=12 if the bank's `row12_i` bit is 1, else 11) and starts just above the logical-bank field.
- R7: In the column phase, `ma_o[C-1:0]` carries the column field. C = 7 + the bank's 2-bit `col_code_i` field (bits [2i+1:2i]), so codes 0..3 give 7..10 bits. `ma_o[10]` equals `ap_val_i`, and the other upper bits are 0.
- R8: The byte offset is dropped before the split: 2 bits when `bus64_i`=0 and 3 bits when `bus64_i`=1. The column takes the lowest remaining bits.
- R9: `ba_o` carries the logical-bank field that sits just above the column. It is 2 bits wide when the bank's `lb4_i` bit is 1. Otherwise it is 1 bit wide and `ba_o[1]`=0.
- R10: `cfg_err_o` is 1 on a hit when the selected bank has column code 0 or 1 in 32-bit mode, or column code 0 in 64-bit mode.
- R11: While `rst_ni` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 32 | Physical byte address |
| col_phase_i | input | 1 | 0 selects the row phase, 1 selects the column phase |
| bus64_i | input | 1 | 1 selects 64-bit data bus mode, 0 selects 32-bit mode |
| ap_val_i | input | 1 | Auto-precharge value driven on ma_o[10] in the column phase |
| bank_en_i | input | 8 | Per-bank enable |
| bank_start_i | input | 96 | Per-bank first 1 MB granule, 12 bits per bank |
| bank_end_i | input | 96 | Per-bank last 1 MB granule, 12 bits per bank |
| row12_i | input | 8 | Per-bank row width: 1 for 12 bits, 0 for 11 bits |
| col_code_i | input | 16 | Per-bank column code, 2 bits per bank, column width is 7 plus the code |
| lb4_i | input | 8 | Per-bank logical bank count: 1 for four, 0 for two |
| cs_o | output | 8 | Chip selects, active high |
| ma_o | output | 14 | Multiplexed memory address |
| ba_o | output | 2 | Logical bank select |
| miss_o | output | 1 | No enabled bank covers the address |
| overlap_o | output | 1 | More than one enabled bank matched |
| cfg_err_o | output | 1 | Selected geometry unsupported for the bus width |

## Verification
The bench builds random window layouts, many of them overlapping and some with banks disabled. This exposes a priority encoder that picks the highest match, or that lets a disabled bank win, because either one asserts the wrong chip select. Random geometries and both bus widths are applied in both phases. A wrong byte-offset shift, or fields stacked in the wrong order, then shows up as a wrong row, column or bank value on the bus. Directed cases cover the 1 GB boundary with a window that spans it, a disabled bank in front of an enabled one, and every column code in each bus mode. These catch a decoder that ignores the limit, and an error flag that is off by one column setting.

// File: rtl/sdr_bank_pkg.sv
package sdr_bank_pkg;
  localparam int unsigned MA_W    = 14;
  localparam int unsigned COL_MIN = 7;
  localparam int unsigned AP_BIT  = 10;

  typedef struct packed {
    logic       row12;
    logic [1:0] col_code;
    logic       lb4;
  } geom_t;
endpackage

// File: rtl/sdr_bank_match.sv
module sdr_bank_match #(
  parameter int unsigned NB = 8,
  parameter int unsigned GW = 12,
  parameter int unsigned LW = 2
) (
  input  logic [GW-1:0]    gran_i,
  input  logic [LW-1:0]    over_i,
  input  logic [NB-1:0]    en_i,
  input  logic [NB*GW-1:0] start_i,
  input  logic [NB*GW-1:0] end_i,
  output logic [NB-1:0]    hit_o
);
  logic in_limit;
  assign in_limit = (over_i == '0);

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic [GW-1:0] lo, hi;
    assign lo = start_i[b*GW +: GW];
    assign hi = end_i[b*GW +: GW];
    assign hit_o[b] = en_i[b] && in_limit && (gran_i >= lo) && (gran_i <= hi);
  end
endmodule

// File: rtl/sdr_prio_sel.sv
module sdr_prio_sel #(
  parameter int unsigned NB = 8,
  localparam int unsigned IW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic [NB-1:0] hit_i,
  output logic [NB-1:0] sel_oh_o,
  output logic [IW-1:0] sel_idx_o,
  output logic          any_o,
  output logic          multi_o
);
  always_comb begin
    sel_oh_o  = '0;
    sel_idx_o = '0;
    any_o     = 1'b0;
    for (int i = NB - 1; i >= 0; i--) begin
      if (hit_i[i]) begin
        sel_oh_o  = '0;
        sel_oh_o[i] = 1'b1;
        sel_idx_o = IW'(i);
        any_o     = 1'b1;
      end
    end
    multi_o = (hit_i & (hit_i - NB'(1))) != '0;
  end
endmodule

// File: rtl/sdr_addr_split.sv
module sdr_addr_split
  import sdr_bank_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0]   addr_i,
  input  logic            bus64_i,
  input  logic            col_phase_i,
  input  logic            ap_val_i,
  input  geom_t           geom_i,
  output logic [MA_W-1:0] ma_o,
  output logic [1:0]      ba_o,
  output logic            cfg_err_o
);
  logic [AW-1:0] word, col_f, lb_f, row_f;
  logic [4:0]    cbits, rbits, lbw;

  always_comb begin
    word  = bus64_i ? (addr_i >> 3) : (addr_i >> 2);
    cbits = 5'(COL_MIN) + 5'(geom_i.col_code);
    lbw   = geom_i.lb4 ? 5'd2 : 5'd1;
    rbits = geom_i.row12 ? 5'd12 : 5'd11;
    col_f = word & ((AW'(1) << cbits) - AW'(1));
    lb_f  = (word >> cbits) & (geom_i.lb4 ? AW'(3) : AW'(1));
    row_f = (word >> (cbits + lbw)) & ((AW'(1) << rbits) - AW'(1));
    if (col_phase_i) begin
      ma_o = col_f[MA_W-1:0];
      ma_o[AP_BIT] = ap_val_i;
    end else begin
      ma_o = row_f[MA_W-1:0];
    end
    ba_o = lb_f[1:0];
    // columns that would fragment the space for this bus width
    cfg_err_o = bus64_i ? (geom_i.col_code == 2'd0) : (geom_i.col_code <= 2'd1);
  end
endmodule

// File: rtl/sdr_bank_mux.sv
module sdr_bank_mux
  import sdr_bank_pkg::*;
#(
  parameter int unsigned NB      = 8,
  parameter int unsigned AW      = 32,
  parameter int unsigned GRAN_LSB = 20,
  parameter int unsigned LIM_LSB  = 30,
  localparam int unsigned GW = AW - GRAN_LSB,
  localparam int unsigned LW = AW - LIM_LSB,
  localparam int unsigned IW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    addr_i,
  input  logic             col_phase_i,
  input  logic             bus64_i,
  input  logic             ap_val_i,
  input  logic [NB-1:0]    bank_en_i,
  input  logic [NB*GW-1:0] bank_start_i,
  input  logic [NB*GW-1:0] bank_end_i,
  input  logic [NB-1:0]    row12_i,
  input  logic [2*NB-1:0]  col_code_i,
  input  logic [NB-1:0]    lb4_i,
  output logic [NB-1:0]    cs_o,
  output logic [MA_W-1:0]  ma_o,
  output logic [1:0]       ba_o,
  output logic             miss_o,
  output logic             overlap_o,
  output logic             cfg_err_o
);
  logic [NB-1:0]   hit, sel_oh;
  logic [IW-1:0]   sel_idx;
  logic            any_hit, multi_hit;
  geom_t           geom;
  logic [MA_W-1:0] ma_d;
  logic [1:0]      ba_d;
  logic            cfg_d;

  sdr_bank_match #(.NB(NB), .GW(GW), .LW(LW)) u_match (
    .gran_i  (addr_i[AW-1:GRAN_LSB]),
    .over_i  (addr_i[AW-1:LIM_LSB]),
    .en_i    (bank_en_i),
    .start_i (bank_start_i),
    .end_i   (bank_end_i),
    .hit_o   (hit)
  );

  sdr_prio_sel #(.NB(NB)) u_prio (
    .hit_i     (hit),
    .sel_oh_o  (sel_oh),
    .sel_idx_o (sel_idx),
    .any_o     (any_hit),
    .multi_o   (multi_hit)
  );

  always_comb begin
    geom.row12    = row12_i[sel_idx];
    geom.col_code = col_code_i[2*sel_idx +: 2];
    geom.lb4      = lb4_i[sel_idx];
  end

  sdr_addr_split #(.AW(AW)) u_split (
    .addr_i      (addr_i),
    .bus64_i     (bus64_i),
    .col_phase_i (col_phase_i),
    .ap_val_i    (ap_val_i),
    .geom_i      (geom),
    .ma_o        (ma_d),
    .ba_o        (ba_d),
    .cfg_err_o   (cfg_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_o      <= '0;
      ma_o      <= '0;
      ba_o      <= '0;
      miss_o    <= 1'b0;
      overlap_o <= 1'b0;
      cfg_err_o <= 1'b0;
    end else begin
      cs_o      <= sel_oh;
      ma_o      <= any_hit ? ma_d : '0;
      ba_o      <= any_hit ? ba_d : '0;
      miss_o    <= ~any_hit;
      overlap_o <= multi_hit;
      cfg_err_o <= any_hit & cfg_d;
    end
  end
endmodule

// File: rtl/sdr_bank_mux_chk.sv
module sdr_bank_mux_chk #(
  parameter int unsigned NB = 8,
  parameter int unsigned AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] addr_i,
  input logic          col_phase_i,
  input logic          ap_val_i,
  input logic [NB-1:0] bank_en_i,
  input logic [NB-1:0] cs_o,
  input logic [13:0]   ma_o,
  input logic [1:0]    ba_o,
  input logic          miss_o,
  input logic          overlap_o,
  input logic          cfg_err_o
);
  assert_cs_onehot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cs_o));

  assert_overlap_has_cs_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overlap_o |-> $countones(cs_o) == 1);

  assert_disabled_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (cs_o & ~$past(bank_en_i)) == '0);

  assert_over_limit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[AW-1:30] != '0) |=> (cs_o == '0) && miss_o);

  assert_miss_clean_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_o |-> (cs_o == '0) && (ma_o == '0) && (ba_o == '0) && !cfg_err_o);

  assert_ap_bit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_phase_i |=> miss_o || (ma_o[10] == $past(ap_val_i)));

  assert_cfg_needs_hit_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> !miss_o);
endmodule

bind sdr_bank_mux sdr_bank_mux_chk #(.NB(NB), .AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .addr_i      (addr_i),
  .col_phase_i (col_phase_i),
  .ap_val_i    (ap_val_i),
  .bank_en_i   (bank_en_i),
  .cs_o        (cs_o),
  .ma_o        (ma_o),
  .ba_o        (ba_o),
  .miss_o      (miss_o),
  .overlap_o   (overlap_o),
  .cfg_err_o   (cfg_err_o)
);

// File: tb/sim_sdr_bank_mux.sv
module sim_sdr_bank_mux;
  localparam int NB = 8;
  localparam int GW = 12;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk = ~clk;

  logic [31:0]      addr;
  logic             col_phase, bus64, ap_val;
  logic [NB-1:0]    en, r12, l4;
  logic [1:0]       cc [NB];
  logic [GW-1:0]    st [NB];
  logic [GW-1:0]    ed [NB];
  logic [NB*GW-1:0] st_flat, ed_flat;
  logic [2*NB-1:0]  cc_flat;

  logic [NB-1:0] cs_o;
  logic [13:0]   ma_o;
  logic [1:0]    ba_o;
  logic          miss_o, overlap_o, cfg_err_o;

  always_comb
    for (int i = 0; i < NB; i++) begin
      st_flat[i*GW +: GW] = st[i];
      ed_flat[i*GW +: GW] = ed[i];
      cc_flat[2*i +: 2]   = cc[i];
    end

  sdr_bank_mux u0 (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .col_phase_i(col_phase),
    .bus64_i(bus64), .ap_val_i(ap_val), .bank_en_i(en), .bank_start_i(st_flat),
    .bank_end_i(ed_flat), .row12_i(r12), .col_code_i(cc_flat), .lb4_i(l4),
    .cs_o(cs_o), .ma_o(ma_o), .ba_o(ba_o), .miss_o(miss_o),
    .overlap_o(overlap_o), .cfg_err_o(cfg_err_o)
  );

  int checks = 0, fails = 0;
  logic done = 1'b0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  // expected values from the requirements
  logic [NB-1:0] e_cs;
  logic [13:0]   e_ma;
  logic [1:0]    e_ba;
  logic          e_miss, e_ovl, e_cfg;

  task automatic model();
    int nhit = 0, win = -1;
    longint unsigned w, c, lbn, rn, colv, lbv, rowv;
    for (int b = 0; b < NB; b++)
      if (en[b] && addr[31:30] == 2'b00 && addr[31:20] >= st[b] && addr[31:20] <= ed[b]) begin
        nhit++;
        if (win < 0) win = b;
      end
    e_cs = '0; e_ma = '0; e_ba = '0; e_cfg = 1'b0;
    e_miss = (nhit == 0);
    e_ovl  = (nhit > 1);
    if (win >= 0) begin
      e_cs[win] = 1'b1;
      w   = longint'(addr) / (bus64 ? 8 : 4);
      c   = longint'(1) << (7 + cc[win]);
      lbn = l4[win] ? 4 : 2;
      rn  = r12[win] ? 4096 : 2048;
      colv = w % c;
      lbv  = (w / c) % lbn;
      rowv = (w / c / lbn) % rn;
      e_ba = 2'(lbv);
      if (col_phase) begin
        e_ma = 14'(colv);
        e_ma[10] = ap_val;
      end else e_ma = 14'(rowv);
      e_cfg = bus64 ? (cc[win] == 0) : (cc[win] < 2);
    end
  endtask

  task automatic apply(string tag);
    model();
    @(posedge clk);
    @(negedge clk);
    chk({tag, " R1 cs"}, 32'(cs_o), 32'(e_cs));
    chk({tag, col_phase ? " R7 ma" : " R6 ma"}, 32'(ma_o), 32'(e_ma));
    chk({tag, " R9 ba"}, 32'(ba_o), 32'(e_ba));
    chk({tag, " R5 miss"}, 32'(miss_o), 32'(e_miss));
    chk({tag, " R4 overlap"}, 32'(overlap_o), 32'(e_ovl));
    chk({tag, " R10 cfg"}, 32'(cfg_err_o), 32'(e_cfg));
  endtask

  task automatic clear_cfg();
    for (int i = 0; i < NB; i++) begin
      st[i] = 12'hfff; ed[i] = 12'h000; cc[i] = 2'd3;
    end
    en = '0; r12 = '0; l4 = '0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    clear_cfg();
    addr = '0; col_phase = 1'b0; bus64 = 1'b0; ap_val = 1'b0;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 cs", 32'(cs_o), 0);
    chk("R11 ma", 32'(ma_o), 0);
    chk("R11 flags", {29'd0, miss_o, overlap_o, cfg_err_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R2: disabled bank 0 in front of enabled bank 1
    st[0] = 0; ed[0] = 100; st[1] = 0; ed[1] = 100; en = 8'b0000_0010;
    addr = 32'h0123_4560; apply("R2");
    // R3: window spans the 1 GB boundary
    st[2] = 12'd1000; ed[2] = 12'd2000; en = 8'b0000_0100; r12[2] = 1'b1;
    addr = 32'h4000_0000; apply("R3");
    addr = 32'h3FFF_FFF8; apply("R3 below");
    // R8: same address, both bus widths, column phase
    clear_cfg(); st[0] = 0; ed[0] = 10; en = 8'b1; cc[0] = 2'd3; l4[0] = 1'b1;
    col_phase = 1'b1; ap_val = 1'b1; addr = 32'h0000_0A58;
    bus64 = 1'b0; apply("R8 b32");
    bus64 = 1'b1; apply("R8 b64");
    // R10: every column code in each mode
    for (int m = 0; m < 2; m++)
      for (int k = 0; k < 4; k++) begin
        bus64 = m[0]; cc[0] = 2'(k); apply("R10 sweep");
      end

    // random layouts
    for (int cfg = 0; cfg < 60; cfg++) begin
      for (int i = 0; i < NB; i++) begin
        st[i]  = 12'($urandom_range(0, 1023));
        ed[i]  = st[i] + 12'($urandom_range(0, 80));
        en[i]  = ($urandom_range(0, 9) < 8);
        r12[i] = 1'($urandom);
        l4[i]  = 1'($urandom);
        cc[i]  = 2'($urandom);
      end
      for (int t = 0; t < 40; t++) begin
        int b = $urandom_range(0, NB - 1);
        addr[19:0] = 20'($urandom);
        if ($urandom_range(0, 9) < 7)
          addr[31:20] = st[b] + 12'($urandom_range(0, 32'(ed[b] - st[b])));
        else if ($urandom_range(0, 4) == 0)
          addr[31:20] = 12'($urandom_range(1024, 4095));
        else
          addr[31:20] = 12'($urandom_range(0, 1023));
        col_phase = 1'($urandom);
        bus64 = 1'($urandom);
        ap_val = 1'($urandom);
        apply("rand");
      end
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog act=hung exp=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule